// File: doc/BRIEF.md
# Tower-Field AES Substitution Box

This block performs the forward byte substitution of the AES cipher as pure combinational logic. It holds neither a 256-entry table nor any registers. The input byte is moved by a linear change of basis into a representation in which GF(2^8) is a quadratic extension of GF(2^4), and GF(2^4) is in turn a quadratic extension of GF(2^2). The multiplicative inverse is taken there with small subfield multipliers. The result is then moved back to the standard polynomial basis and passed through the AES affine transform.

The block suits a byte-serial cipher datapath, where one or two copies are shared across the state bytes and the key schedule and gate area counts for more than depth. The extension constants and both basis-change matrices are derived at elaboration time from the field definitions, so the source holds no hand-copied tables.

Top module: `sbox_tower`

## Requirements
- R1: For every input byte the output equals the AES forward S-box value: the inverse of the byte in GF(2^8) modulo x^8+x^4+x^3+x+1, followed by the affine transform.
- R2: The affine step sets output bit i to x[i] ^ x[(i+4)%8] ^ x[(i+5)%8] ^ x[(i+6)%8] ^ x[(i+7)%8] ^ k[i], where k = 8'h63, x is the inverse and bit 0 is the least significant bit.
- R3: The zero byte is treated as its own inverse, so input 8'h00 gives output 8'h63.
- R4: Input 8'h01, which is its own inverse, gives output 8'h7C.
- R5: Input 8'h53, whose inverse is 8'hCA, gives output 8'hED.
- R6: The output depends only on the present input and settles in the same cycle the input is applied, so applying an earlier byte again reproduces its earlier result.
- R7: No input is mapped to itself or to its bitwise complement.
- R8: For every nonzero input, the internal inverse multiplied by the input in the standard polynomial basis gives 8'h01.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| byte_in | input | 8 | Byte to substitute, standard AES polynomial basis |
| byte_out | output | 8 | Substituted byte |

## Verification
The two steps that meet on the same byte in the same cycle are the zero-inverse convention and the affine constant. For input zero the inversion must yield zero, so the output is the affine constant alone. For input one the inversion returns its argument, so the affine matrix alone sets the output. These bytes are applied back to back with other values and compared against a reference computed by brute-force search for the inverse. The full sweep of 256 inputs then checks that the tower inversion and the output basis change agree with that reference for every byte, and that no byte lands on itself or on its complement.

// File: rtl/sbox_tower.sv
module sbox_tower #(
  parameter logic [7:0] AFF_CONST = 8'h63,
  parameter logic [8:0] AES_POLY  = 9'h11B
) (
  input  logic [7:0] byte_in,
  output logic [7:0] byte_out
);

  localparam logic [1:0] PHI = 2'b10;

  function automatic logic [1:0] f4_mul(input logic [1:0] a, input logic [1:0] b);
    f4_mul = {(a[1] & b[1]) ^ (a[1] & b[0]) ^ (a[0] & b[1]),
              (a[1] & b[1]) ^ (a[0] & b[0])};
  endfunction

  function automatic logic [1:0] f4_sq(input logic [1:0] a);
    f4_sq = {a[1], a[1] ^ a[0]};
  endfunction

  function automatic logic [3:0] f16_mul(input logic [3:0] a, input logic [3:0] b);
    logic [1:0] hh;
    hh = f4_mul(a[3:2], b[3:2]);
    f16_mul = {hh ^ f4_mul(a[3:2], b[1:0]) ^ f4_mul(a[1:0], b[3:2]),
               f4_mul(hh, PHI) ^ f4_mul(a[1:0], b[1:0])};
  endfunction

  function automatic logic [3:0] f16_inv(input logic [3:0] a);
    logic [1:0] d, di;
    d  = f4_mul(f4_sq(a[3:2]), PHI) ^ f4_mul(a[3:2], a[1:0]) ^ f4_sq(a[1:0]);
    di = f4_sq(d);
    f16_inv = {f4_mul(a[3:2], di), f4_mul(a[1:0] ^ a[3:2], di)};
  endfunction

  function automatic logic [7:0] f256_mul(input logic [7:0] a, input logic [7:0] b,
                                          input logic [3:0] lam);
    logic [3:0] hh;
    hh = f16_mul(a[7:4], b[7:4]);
    f256_mul = {hh ^ f16_mul(a[7:4], b[3:0]) ^ f16_mul(a[3:0], b[7:4]),
                f16_mul(hh, lam) ^ f16_mul(a[3:0], b[3:0])};
  endfunction

  function automatic logic [3:0] pick_lambda();
    logic hit, done;
    pick_lambda = 4'h1;
    done = 1'b0;
    for (int l = 1; l < 16; l++) begin
      hit = 1'b0;
      for (int s = 0; s < 16; s++)
        if ((f16_mul(4'(s), 4'(s)) ^ 4'(s)) == 4'(l)) hit = 1'b1;
      if (!hit && !done) begin
        pick_lambda = 4'(l);
        done = 1'b1;
      end
    end
  endfunction

  localparam logic [3:0] LAM = pick_lambda();

  function automatic logic [7:0] apply_map(input logic [63:0] m, input logic [7:0] a);
    apply_map = 8'h00;
    for (int k = 0; k < 8; k++)
      if (a[k]) apply_map = apply_map ^ m[8*k +: 8];
  endfunction

  function automatic logic [63:0] build_fwd();
    logic [7:0] p [0:8];
    logic [7:0] v, acc;
    logic done;
    build_fwd = '0;
    done = 1'b0;
    for (int h = 0; h < 16; h++)
      for (int l = 0; l < 16; l++) begin
        v = {4'(h), 4'(l)};
        p[0] = 8'h01;
        for (int k = 1; k < 9; k++) p[k] = f256_mul(p[k-1], v, LAM);
        acc = 8'h00;
        for (int k = 0; k < 9; k++)
          if (AES_POLY[k]) acc = acc ^ p[k];
        if (v != 8'h00 && acc == 8'h00 && !done) begin
          done = 1'b1;
          for (int k = 0; k < 8; k++) build_fwd[8*k +: 8] = p[k];
        end
      end
  endfunction

  localparam logic [63:0] TO_TOWER = build_fwd();

  function automatic logic [63:0] build_back();
    logic [7:0] a;
    build_back = '0;
    for (int j = 0; j < 8; j++)
      for (int h = 0; h < 16; h++)
        for (int l = 0; l < 16; l++) begin
          a = {4'(h), 4'(l)};
          if (apply_map(TO_TOWER, a) == (8'h01 << j)) build_back[8*j +: 8] = a;
        end
  endfunction

  localparam logic [63:0] FROM_TOWER = build_back();

  logic [7:0] tw_in, tw_inv, inv_std;
  logic [3:0] tw_d, tw_di;

  assign tw_in = apply_map(TO_TOWER, byte_in);
  assign tw_d  = f16_mul(f16_mul(tw_in[7:4], tw_in[7:4]), LAM)
               ^ f16_mul(tw_in[7:4], tw_in[3:0])
               ^ f16_mul(tw_in[3:0], tw_in[3:0]);
  assign tw_di  = f16_inv(tw_d);
  assign tw_inv = {f16_mul(tw_in[7:4], tw_di), f16_mul(tw_in[3:0] ^ tw_in[7:4], tw_di)};
  assign inv_std = apply_map(FROM_TOWER, tw_inv);

  always_comb begin
    for (int i = 0; i < 8; i++)
      byte_out[i] = inv_std[i] ^ inv_std[(i+4)%8] ^ inv_std[(i+5)%8]
                  ^ inv_std[(i+6)%8] ^ inv_std[(i+7)%8] ^ AFF_CONST[i];
  end

  function automatic logic [7:0] std_mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] x;
    std_mul = 8'h00;
    x = a;
    for (int k = 0; k < 8; k++) begin
      if (b[k]) std_mul = std_mul ^ x;
      x = x[7] ? ((x << 1) ^ AES_POLY[7:0]) : (x << 1);
    end
  endfunction

  always_comb begin
    assert_inverse_product_R8: assert (byte_in == 8'h00 || std_mul(byte_in, inv_std) == 8'h01);
    assert_zero_inverse_R3: assert (byte_in != 8'h00 || inv_std == 8'h00);
    assert_no_fixed_point_R7: assert (byte_out != byte_in);
    assert_no_opposite_point_R7: assert (byte_out != ~byte_in);
  end

endmodule

// File: tb/sbox_tower_tb.sv
module sbox_tower_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [7:0] byte_in = 8'h00;
  logic [7:0] byte_out;
  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  logic [7:0] in_q[$];
  logic [7:0] exp_q[$];
  string tag_q[$];

  always #4 clk = ~clk;

  sbox_tower u_dut (.byte_in(byte_in), .byte_out(byte_out));

  function automatic logic [7:0] ref_mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] x;
    ref_mul = 8'h00;
    x = a;
    for (int k = 0; k < 8; k++) begin
      if (b[k]) ref_mul = ref_mul ^ x;
      x = x[7] ? ((x << 1) ^ 8'h1B) : (x << 1);
    end
  endfunction

  function automatic logic [7:0] ref_sbox(input logic [7:0] a);
    logic [7:0] inv;
    inv = 8'h00;
    for (int y = 1; y < 256; y++)
      if (ref_mul(a, 8'(y)) == 8'h01) inv = 8'(y);
    for (int i = 0; i < 8; i++)
      ref_sbox[i] = inv[i] ^ inv[(i+4)%8] ^ inv[(i+5)%8] ^ inv[(i+6)%8]
                  ^ inv[(i+7)%8] ^ ((8'h63 >> i) & 8'h01) != 8'h00;
  endfunction

  task automatic drive(input logic [7:0] v, input logic [7:0] e, input string tag);
    @(posedge clk);
    byte_in = v;
    in_q.push_back(v);
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      logic [7:0] v, e;
      string t;
      v = in_q.pop_front();
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      total++;
      if (byte_out !== e) begin
        bad++;
        $display("FAIL %s in=%02h actual=%02h expected=%02h", t, v, byte_out, e);
      end
      if (t == "R1,R2") begin
        total++;
        if (byte_out == v || byte_out == ~v) begin
          bad++;
          $display("FAIL R7 in=%02h actual=%02h expected not %02h or %02h", v, byte_out, v, ~v);
        end
      end
    end
  end

  initial begin
    #(8 * 200000);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    total++;
    if (byte_out !== 8'h63) begin
      bad++;
      $display("FAIL R3 initial actual=%02h expected=63", byte_out);
    end
    drive(8'h00, 8'h63, "R3");
    drive(8'h01, 8'h7C, "R4");
    drive(8'h53, 8'hED, "R5");
    drive(8'h00, 8'h63, "R6");
    drive(8'h53, 8'hED, "R6");
    drive(8'h01, 8'h7C, "R6");
    drive(8'hFF, 8'h16, "R1");
    drive(8'h80, 8'hCD, "R1");
    for (int a = 0; a < 256; a++)
      drive(8'(a), ref_sbox(8'(a)), "R1,R2");
    for (int a = 255; a >= 0; a -= 17)
      drive(8'(a), ref_sbox(8'(a)), "R6");
    repeat (3) @(posedge clk);
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule